// File: doc/BRIEF.md
# Remote error indication count generator

This block collects the line parity error counts that the receive path reports, one count per received frame, and turns them into the two remote error indication bytes, M0 and M1, once per transmitted frame. Receive and transmit frames are not aligned in time. Counts therefore pile up in an accumulator between insertions, and each insertion drains it.

The value sent in one frame is capped by a mode-dependent limit. The limit is 1536 in combined M0/M1 mode and 255 in M1-only mode. Any excess stays in the accumulator and goes out in later frames. A forced-error control can replace the bytes sent with a value taken from a 16-bit override input. The accumulator keeps draining as usual while this override is active. Computing parity and placing the bytes into the outgoing frame are handled elsewhere.

Top module: `reiGen`

## Requirements
- R1: After reset, m0Byte and m1Byte are 0x00, reiValid is low and the accumulator is empty.
- R2: Each cycle with errValid high adds errCount to the accumulator. Counts from several strobes add up when no insertion occurs between them.
- R3: On an insertion (insValid high) with the accumulated value at or below the mode limit, the whole value is sent and the accumulator becomes zero.
- R4: On an insertion with the accumulated value above the mode limit, the limit is sent and the remainder stays for later insertions.
- R5: modeM1Only = 0 selects combined mode with a limit of 1536. modeM1Only = 1 selects M1-only mode with a limit of 255.
- R6: In combined mode m0Byte carries bits 15:8 of the sent value and m1Byte carries bits 7:0. In M1-only mode m0Byte is 0x00 and m1Byte carries the sent value.
- R7: When errValid and insValid are high in the same cycle, the remainder is formed first and the new count is then added to it, so no count is lost.
- R8: The accumulator saturates at 4095 instead of wrapping.
- R9: An insertion with forceEn high drives m0Byte = forceValue[15:8] and m1Byte = forceValue[7:0] in either mode. The accumulator drains exactly as it would without forceEn.
- R10: The outputs are registered. They take a new value at the clock edge that samples insValid, and reiValid pulses high for the following cycle. Without an insertion the bytes hold their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errValid | input | 1 | Receive-side count strobe |
| errCount | input | 12 | Parity error count reported with errValid |
| insValid | input | 1 | Transmit-side insertion strobe, one per frame |
| modeM1Only | input | 1 | 0 = combined M0/M1 mode, 1 = M1-only mode |
| forceEn | input | 1 | Use forceValue for this insertion |
| forceValue | input | 16 | Override value, upper byte to M0 and lower byte to M1 |
| m0Byte | output | 8 | M0 byte for the current transmit frame |
| m1Byte | output | 8 | M1 byte for the current transmit frame |
| reiValid | output | 1 | Pulses for one cycle after each insertion |

## Verification
The assertions check on every cycle that:
- an unforced output never exceeds the limit of the mode it was sent in;
- M0 is zero in M1-only mode;
- the accumulator clears after an insertion that fits and stays put when nothing happens;
- it pins at 4095 on overflow;
- a same-cycle count lands whole in an emptied accumulator;
- forced bytes match the override;
- the output pulse and hold timing are correct.

Only the bench's scenarios can show the exact amounts across a chain of insertions. These include:
- remainders spread over several frames after saturation;
- a mode change with a leftover;
- the size of the drain behind a forced insertion, which is visible only in the value of the next frame.

// File: rtl/reiGenPkg.sv
package reiGenPkg;

  typedef struct packed {
    logic addCount;
    logic insertNow;
    logic forceOut;
    logic m1Only;
  } reiStrobe_t;

endpackage

// File: rtl/reiCtrl.sv
module reiCtrl
  import reiGenPkg::*;
(
  input  logic       errValid,
  input  logic       insValid,
  input  logic       forceEn,
  input  logic       modeM1Only,
  output reiStrobe_t strobes
);

  // Forcing only matters on an insertion; mode is sampled with every step.
  always_comb begin
    strobes.addCount  = errValid;
    strobes.insertNow = insValid;
    strobes.forceOut  = insValid & forceEn;
    strobes.m1Only    = modeM1Only;
  end

endmodule

// File: rtl/reiDatapath.sv
module reiDatapath
  import reiGenPkg::*;
#(
  parameter int ACC_W      = 12,
  parameter int CNT_W      = 12,
  parameter int VAL_W      = 16,
  parameter int COMB_LIMIT = 1536,
  parameter int M1_LIMIT   = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  reiStrobe_t       strobes,
  input  logic [CNT_W-1:0] errCount,
  input  logic [VAL_W-1:0] forceValue,
  output logic [7:0]       m0Byte,
  output logic [7:0]       m1Byte,
  output logic             reiValid
);

  localparam int SUM_W   = ACC_W + 1;
  localparam int ACC_MAX = (1 << ACC_W) - 1;
  localparam int HI_W    = VAL_W - 8;

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] limitSel;
  logic [ACC_W-1:0] sentVal;
  logic [ACC_W-1:0] remainVal;
  logic [ACC_W-1:0] accNext;
  logic [SUM_W-1:0] sumVal;
  logic [VAL_W-1:0] normVal;
  logic [7:0]       m0Next;
  logic [7:0]       m1Next;
  logic             lastForcedQ;
  logic             lastM1Q;

  // Cap and remainder
  always_comb begin
    limitSel  = strobes.m1Only ? ACC_W'(M1_LIMIT) : ACC_W'(COMB_LIMIT);
    sentVal   = (accQ > limitSel) ? limitSel : accQ;
    remainVal = strobes.insertNow ? (accQ - sentVal) : accQ;
    sumVal    = {1'b0, remainVal} +
                (strobes.addCount ? SUM_W'(errCount) : SUM_W'(0));
    accNext   = sumVal[ACC_W] ? ACC_W'(ACC_MAX) : sumVal[ACC_W-1:0];
    normVal   = VAL_W'(sentVal);
  end

  // Byte layout per mode, or override
  generate
    if (HI_W > 8) begin : g_wideHi
      always_comb begin
        if (strobes.forceOut) begin
          m0Next = forceValue[15:8];
          m1Next = forceValue[7:0];
        end else if (strobes.m1Only) begin
          m0Next = 8'h00;
          m1Next = normVal[7:0];
        end else begin
          m0Next = normVal[15:8];
          m1Next = normVal[7:0];
        end
      end
    end else begin : g_narrowHi
      always_comb begin
        if (strobes.forceOut) begin
          m0Next = 8'(forceValue[VAL_W-1:8]);
          m1Next = forceValue[7:0];
        end else if (strobes.m1Only) begin
          m0Next = 8'h00;
          m1Next = normVal[7:0];
        end else begin
          m0Next = 8'(normVal[VAL_W-1:8]);
          m1Next = normVal[7:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ        <= '0;
      m0Byte      <= 8'h00;
      m1Byte      <= 8'h00;
      reiValid    <= 1'b0;
      lastForcedQ <= 1'b0;
      lastM1Q     <= 1'b0;
    end else begin
      accQ     <= accNext;
      reiValid <= strobes.insertNow;
      if (strobes.insertNow) begin
        m0Byte      <= m0Next;
        m1Byte      <= m1Next;
        lastForcedQ <= strobes.forceOut;
        lastM1Q     <= strobes.m1Only;
      end
    end
  end

  // R4 / R5: an unforced value never exceeds its mode limit
  assert_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reiValid && !lastForcedQ) |->
      ({m0Byte, m1Byte} <= (lastM1Q ? 16'(M1_LIMIT) : 16'(COMB_LIMIT))));

  // R6: M1-only leaves M0 at zero
  assert_m0zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reiValid && !lastForcedQ && lastM1Q) |-> (m0Byte == 8'h00));

  // R3: a fitting value is fully drained
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.insertNow && !strobes.addCount &&
     (accQ <= (strobes.m1Only ? ACC_W'(M1_LIMIT) : ACC_W'(COMB_LIMIT))))
      |=> (accQ == '0));

  // R2: nothing happens, nothing changes
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.insertNow && !strobes.addCount) |=> $stable(accQ));

  // R8: saturate rather than wrap
  assert_sat_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.addCount && !strobes.insertNow &&
     (({1'b0, accQ} + SUM_W'(errCount)) > SUM_W'(ACC_MAX)))
      |=> (accQ == ACC_W'(ACC_MAX)));

  // R7: same-cycle count lands whole after a full drain
  assert_merge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.insertNow && strobes.addCount &&
     (accQ <= (strobes.m1Only ? ACC_W'(M1_LIMIT) : ACC_W'(COMB_LIMIT))))
      |=> (accQ == ACC_W'($past(errCount))));

  // R9: override reaches the bytes
  assert_force_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceOut |=> ({m0Byte, m1Byte} == 16'($past(forceValue))));

  // R10: one pulse per insertion, bytes held otherwise
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.insertNow |=> reiValid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.insertNow |=> (!reiValid && $stable(m0Byte) && $stable(m1Byte)));

endmodule

// File: rtl/reiGen.sv
module reiGen
  import reiGenPkg::*;
#(
  parameter int ACC_W      = 12,
  parameter int CNT_W      = 12,
  parameter int COMB_LIMIT = 1536,
  parameter int M1_LIMIT   = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             errValid,
  input  logic [CNT_W-1:0] errCount,
  input  logic             insValid,
  input  logic             modeM1Only,
  input  logic             forceEn,
  input  logic [15:0]      forceValue,
  output logic [7:0]       m0Byte,
  output logic [7:0]       m1Byte,
  output logic             reiValid
);

  reiStrobe_t strobes;

  reiCtrl u_ctrl (
    .errValid   (errValid),
    .insValid   (insValid),
    .forceEn    (forceEn),
    .modeM1Only (modeM1Only),
    .strobes    (strobes)
  );

  reiDatapath #(
    .ACC_W      (ACC_W),
    .CNT_W      (CNT_W),
    .VAL_W      (16),
    .COMB_LIMIT (COMB_LIMIT),
    .M1_LIMIT   (M1_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .errCount   (errCount),
    .forceValue (forceValue),
    .m0Byte     (m0Byte),
    .m1Byte     (m1Byte),
    .reiValid   (reiValid)
  );

endmodule

// File: tb/sim_reiGen.sv
module sim_reiGen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        errValid = 1'b0;
  logic [11:0] errCount = '0;
  logic        insValid = 1'b0;
  logic        modeM1Only = 1'b0;
  logic        forceEn = 1'b0;
  logic [15:0] forceValue = '0;
  logic [7:0]  m0Byte;
  logic [7:0]  m1Byte;
  logic        reiValid;

  always #5 clk = ~clk;

  reiGen u0 (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errCount(errCount),
    .insValid(insValid), .modeM1Only(modeM1Only), .forceEn(forceEn),
    .forceValue(forceValue), .m0Byte(m0Byte), .m1Byte(m1Byte),
    .reiValid(reiValid)
  );

  typedef struct {
    logic [15:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int       checks = 0;
  int       fails = 0;
  int       modelAcc = 0;
  logic     modelM1 = 1'b0;
  logic [15:0] lastOut = '0;
  bit       done = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus plus the reference model
  task automatic step(input bit add, input int cnt, input bit ins,
                      input bit frc, input logic [15:0] fval, input string tag);
    int lim;
    int sent;
    logic [15:0] e;
    @(negedge clk);
    errValid   = add;
    errCount   = 12'(cnt);
    insValid   = ins;
    forceEn    = frc;
    forceValue = fval;
    modeM1Only = modelM1;
    if (ins) begin
      lim  = modelM1 ? 255 : 1536;
      sent = (modelAcc > lim) ? lim : modelAcc;
      modelAcc -= sent;
      if (frc) e = fval;
      else if (modelM1) e = {8'h00, 8'(sent)};
      else e = 16'(sent);
      expQ.push_back('{val: e, tag: tag});
    end
    if (add) begin
      modelAcc += cnt;
      if (modelAcc > 4095) modelAcc = 4095;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 16'h0, "");
  endtask

  // Monitor: compares each produced value against the scoreboard
  always @(negedge clk) begin
    if (rstN && reiValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected reiValid", {m0Byte, m1Byte}, 16'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check({m0Byte, m1Byte} == it.val, it.tag, {m0Byte, m1Byte}, it.val);
        lastOut = it.val;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(m0Byte == 8'h00 && m1Byte == 8'h00 && !reiValid, "R1 reset outputs",
          {m0Byte, m1Byte}, 16'h0);
    rstN = 1'b1;
    idle(1);
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R1 empty accumulator sends 0");

    // R2 / R3 accumulate then fully drain
    step(1'b1, 5, 1'b0, 1'b0, 16'h0, "");
    step(1'b1, 7, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R2 sum of two counts = 12");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R3 cleared after fit");

    // R4 / R6 over the combined limit with remainder
    step(1'b1, 2000, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R4 capped at 1536, R6 m0=0x06");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R4 remainder 464");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R3 drained to 0");

    // R10 hold without insertion
    step(1'b1, 33, 1'b1, 1'b0, 16'h0, "R10 setup");
    idle(4);
    check({m0Byte, m1Byte} == lastOut && !reiValid, "R10 bytes held while idle",
          {m0Byte, m1Byte}, lastOut);
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R10 held count 33 sent next");

    // R5 exact boundary, combined
    step(1'b1, 1536, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 exactly 1536 fits");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 nothing left after 1536");

    // R5 / R6 M1-only mode
    modelM1 = 1'b1;
    step(1'b1, 300, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 M1-only capped at 255, R6 m0=0");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R6 M1-only remainder 45");
    step(1'b1, 255, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 exactly 255 fits");
    // leftover carried across a mode change
    step(1'b1, 400, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 255 before mode change");
    modelM1 = 1'b0;
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R5 leftover 145 in combined mode");

    // R7 same-cycle add and insert
    step(1'b1, 1600, 1'b0, 1'b0, 16'h0, "");
    step(1'b1, 100, 1'b1, 1'b0, 16'h0, "R7 1536 sent alongside new count");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R7 remainder 64 plus 100 = 164");

    // R8 saturation
    step(1'b1, 4000, 1'b0, 1'b0, 16'h0, "");
    step(1'b1, 500, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R8 first 1536 of 4095");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R8 second 1536");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R8 last 1023 shows saturation");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R8 empty after drain");

    // R9 forced insertion drains as usual
    step(1'b1, 2000, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b1, 16'h0123, "R9 forced value in combined mode");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R9 drain under force left 464");
    modelM1 = 1'b1;
    step(1'b1, 20, 1'b0, 1'b0, 16'h0, "");
    step(1'b0, 0, 1'b1, 1'b1, 16'h00C8, "R9 forced value in M1-only mode");
    step(1'b0, 0, 1'b1, 1'b0, 16'h0, "R9 drained to 0 under force");
    modelM1 = 1'b0;

    idle(3);
    check(expQ.size() == 0, "R10 every insertion produced a pulse",
          16'(expQ.size()), 16'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule